// File: doc/BRIEF.md
# Two-Alarm Time Comparator with Interrupt / Square-Wave Pin

This block watches a calendar clock's BCD time and compares it against two programmable alarm sets. The first alarm covers seconds, minutes, hours and a day-or-date byte. The second alarm covers minutes, hours and the day-or-date byte, and it only fires at the top of a minute. Each alarm byte has its own mask bit, so one alarm can repeat every second, minute, hour or day, or fire on a single full date match. A match sets a sticky flag. Software clears a flag by writing zero to its bit.

A single active-low pin has two modes. In interrupt mode it reports the enabled flags. In square-wave mode it forwards one of four square-wave sources chosen by a two-bit rate field. When the system runs from its backup supply, the pin's driver is released unless a control bit keeps it on.

The time counter sits outside the block and supplies the time bytes together with a one-cycle strobe per second. Registers are written through a simple address / data / enable port.

Top module: `alarm_irq_unit`

Register addresses:
- 0 to 3: alarm-1 seconds, minutes, hour and day/date.
- 4 to 6: alarm-2 minutes, hour and day/date.
- 7: control.
- 8: flag status.

Control bits:
- bit 6: keep the pin driven while on battery.
- bits 4:3: rate select.
- bit 2: interrupt mode (1) or square-wave mode (0).
- bit 1: alarm-2 interrupt enable.
- bit 0: alarm-1 interrupt enable.

Status bits:
- bit 1: alarm-2 flag.
- bit 0: alarm-1 flag.

## Requirements
- R1: After reset the control byte is 0x1C: interrupt mode, rate 11, both enables 0 and battery drive 0. Both flags are 0 and the pin is high and driven.
- R2: Bit 7 of an alarm byte masks its field, and a masked field is left out of the comparison. With all four alarm-1 bytes masked, alarm 1 matches on every seconds strobe.
- R3: In a day/date alarm byte, bit 6 = 0 compares bits 5:0 with the date, and bit 6 = 1 compares them with the day of week. With no masks set, alarm 1 needs seconds, minutes, hour and day/date to be equal.
- R4: Alarm 2 matches only when the seconds byte is 00, together with each of its unmasked minute, hour and day/date fields. With all alarm-2 masks set it fires once per minute.
- R5: A flag sets on the clock edge where the seconds strobe is high and its alarm matches. This happens in either pin mode. Without a strobe, no flag sets.
- R6: Writing 0 to a status bit clears that flag, and writing 1 leaves it unchanged. If a set and a clear land on the same edge, the set wins.
- R7: In interrupt mode the pin is low exactly when (alarm-1 flag and alarm-1 enable) or (alarm-2 flag and alarm-2 enable) is true.
- R8: In square-wave mode the pin equals the square-wave source bit selected by the rate field. Rate 00 selects bit 0 (1 Hz) and rate 11 selects bit 3 (8.192 kHz).
- R9: When the on-battery input is high and control bit 6 is 0, the pin's output enable is 0. In every other case it is 1.
- R10: Hour comparison uses bits 6:0 as stored, so the 12/24 bit and the PM bit must both be equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle strobe marking a new second on the time inputs |
| timeSec | input | 8 | BCD seconds |
| timeMin | input | 8 | BCD minutes |
| timeHour | input | 8 | Hour byte, including the 12/24 and PM bits |
| timeDay | input | 8 | Day of week |
| timeDate | input | 8 | BCD date of month |
| sqSrc | input | 4 | Square-wave sources, bit 0 slowest to bit 3 fastest |
| onBattery | input | 1 | High while the system runs from its backup supply |
| regWrEn | input | 1 | Register write enable |
| regAddr | input | 4 | Register address |
| regWrData | input | 8 | Register write data |
| alarmFlags | output | 2 | Flag status: bit 1 alarm 2, bit 0 alarm 1 |
| irqPinN | output | 1 | Active-low interrupt or square-wave level |
| irqPinOe | output | 1 | Pin driver enable; 0 means high impedance |

## Verification
The assertions assume that register writes and seconds strobes are single-cycle pulses. They also assume that the time bytes are stable in any cycle where the strobe is high, because matches are checked only against that strobe. The stimulus changes time bytes and write fields only at falling edges, with the strobe low. The one test that raises a status write and the strobe together does so on purpose, to exercise the rule that a set beats a clear.

// File: rtl/alarm_irq_pkg.sv
`timescale 1ns/1ps
package alarm_irq_pkg;
  localparam int BYTE_W        = 8;
  localparam int NUM_ALARMS    = 2;
  localparam int NUM_ALM_BYTES = 7;
  localparam int ADDR_W        = 4;
  localparam int ADDR_CTRL     = NUM_ALM_BYTES;
  localparam int ADDR_STAT     = NUM_ALM_BYTES + 1;
  localparam int RATE_W        = 2;
  localparam int NUM_RATES     = 1 << RATE_W;
  localparam int RATE_LSB      = 3;
  localparam int BIT_INTMODE   = 2;
  localparam int BIT_BATDRV    = 6;
  localparam int BIT_MASK      = 7;
  localparam int BIT_DAYSEL    = 6;
  localparam logic [BYTE_W-1:0] CTRL_RST = 8'h1C;

  localparam int A1_SEC = 0;
  localparam int A1_MIN = 1;
  localparam int A1_HR  = 2;
  localparam int A1_DD  = 3;
  localparam int A2_MIN = 4;
  localparam int A2_HR  = 5;
  localparam int A2_DD  = 6;

  typedef struct packed {
    logic [NUM_ALM_BYTES-1:0] wrAlm;
    logic                     wrCtrl;
    logic                     wrStat;
    logic                     evalTick;
  } strobe_t;
endpackage

// File: rtl/alarm_irq_ctrl.sv
`timescale 1ns/1ps
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  secTick,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [BYTE_W-1:0]     regWrData,
  input  logic [NUM_ALARMS-1:0] matchHit,
  output strobe_t               strb,
  output logic [NUM_ALARMS-1:0] flags
);
  always_comb begin
    for (int i = 0; i < NUM_ALM_BYTES; i++)
      strb.wrAlm[i] = regWrEn && (regAddr == ADDR_W'(i));
    strb.wrCtrl   = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
    strb.wrStat   = regWrEn && (regAddr == ADDR_W'(ADDR_STAT));
    strb.evalTick = secTick;
  end

  assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrAlm, strb.wrCtrl, strb.wrStat}));

  for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)
        flags[g] <= 1'b0;
      else if (strb.evalTick && matchHit[g])
        flags[g] <= 1'b1;
      else if (strb.wrStat && !regWrData[g])
        flags[g] <= 1'b0;
    end

    assert_flag_clear_by_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flags[g]) |-> $past(regWrEn && regAddr == ADDR_W'(ADDR_STAT) && !regWrData[g]));

    assert_flag_set_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[g]) |-> $past(secTick));
  end
endmodule

// File: rtl/alarm_irq_dp.sv
`timescale 1ns/1ps
module alarm_irq_dp
  import alarm_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [BYTE_W-1:0]     regWrData,
  input  logic [BYTE_W-1:0]     timeSec,
  input  logic [BYTE_W-1:0]     timeMin,
  input  logic [BYTE_W-1:0]     timeHour,
  input  logic [BYTE_W-1:0]     timeDay,
  input  logic [BYTE_W-1:0]     timeDate,
  input  logic [NUM_RATES-1:0]  sqSrc,
  input  logic                  onBattery,
  input  logic [NUM_ALARMS-1:0] flags,
  output logic [NUM_ALARMS-1:0] matchHit,
  output logic                  irqPinN,
  output logic                  irqPinOe
);
  logic [BYTE_W-1:0] almByte [NUM_ALM_BYTES];
  logic [BYTE_W-1:0] ctrlReg;
  logic [RATE_W-1:0] rateSel;
  logic              irqLevel;

  for (genvar g = 0; g < NUM_ALM_BYTES; g++) begin : g_alm
    always_ff @(posedge clk) begin
      if (!rstN)
        almByte[g] <= '0;
      else if (strb.wrAlm[g])
        almByte[g] <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      ctrlReg <= CTRL_RST;
    else if (strb.wrCtrl)
      ctrlReg <= regWrData;
  end

  function automatic logic fieldHit(input logic [BYTE_W-1:0] a, input logic [BYTE_W-1:0] t);
    return a[BIT_MASK] || (a[BIT_MASK-1:0] == t[BIT_MASK-1:0]);
  endfunction

  function automatic logic dayDateHit(input logic [BYTE_W-1:0] a,
                                      input logic [BYTE_W-1:0] day,
                                      input logic [BYTE_W-1:0] date);
    if (a[BIT_MASK])
      return 1'b1;
    else if (a[BIT_DAYSEL])
      return a[BIT_DAYSEL-1:0] == day[BIT_DAYSEL-1:0];
    else
      return a[BIT_DAYSEL-1:0] == date[BIT_DAYSEL-1:0];
  endfunction

  always_comb begin
    matchHit[0] = fieldHit(almByte[A1_SEC], timeSec) &&
                  fieldHit(almByte[A1_MIN], timeMin) &&
                  fieldHit(almByte[A1_HR],  timeHour) &&
                  dayDateHit(almByte[A1_DD], timeDay, timeDate);
    matchHit[1] = (timeSec[BIT_MASK-1:0] == '0) &&
                  fieldHit(almByte[A2_MIN], timeMin) &&
                  fieldHit(almByte[A2_HR],  timeHour) &&
                  dayDateHit(almByte[A2_DD], timeDay, timeDate);
  end

  assign rateSel  = ctrlReg[RATE_LSB +: RATE_W];
  assign irqLevel = |(flags & ctrlReg[NUM_ALARMS-1:0]);
  assign irqPinN  = ctrlReg[BIT_INTMODE] ? ~irqLevel : sqSrc[rateSel];
  assign irqPinOe = ~onBattery | ctrlReg[BIT_BATDRV];

  assert_alarm2_top_of_minute_R4: assert property (@(posedge clk) disable iff (!rstN)
    matchHit[1] |-> (timeSec[BIT_MASK-1:0] == '0));

  assert_alarm1_sec_equal_R3: assert property (@(posedge clk) disable iff (!rstN)
    (matchHit[0] && !almByte[A1_SEC][BIT_MASK]) |-> (timeSec[BIT_MASK-1:0] == almByte[A1_SEC][BIT_MASK-1:0]));

  assert_quiet_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCtrl && regWrData[BIT_INTMODE] && regWrData[NUM_ALARMS-1:0] == '0) |=> irqPinN);
endmodule

// File: rtl/alarm_irq_unit.sv
`timescale 1ns/1ps
module alarm_irq_unit
  import alarm_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        secTick,
  input  logic [7:0]  timeSec,
  input  logic [7:0]  timeMin,
  input  logic [7:0]  timeHour,
  input  logic [7:0]  timeDay,
  input  logic [7:0]  timeDate,
  input  logic [3:0]  sqSrc,
  input  logic        onBattery,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [1:0]  alarmFlags,
  output logic        irqPinN,
  output logic        irqPinOe
);
  strobe_t               strb;
  logic [NUM_ALARMS-1:0] matchHit;

  alarm_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .matchHit(matchHit),
    .strb(strb), .flags(alarmFlags)
  );

  alarm_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .timeSec(timeSec), .timeMin(timeMin), .timeHour(timeHour),
    .timeDay(timeDay), .timeDate(timeDate), .sqSrc(sqSrc),
    .onBattery(onBattery), .flags(alarmFlags), .matchHit(matchHit),
    .irqPinN(irqPinN), .irqPinOe(irqPinOe)
  );
endmodule

// File: tb/alarm_irq_unit_bench.sv
`timescale 1ns/1ps
module alarm_irq_unit_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, secTick, onBattery, regWrEn;
  logic [7:0] timeSec, timeMin, timeHour, timeDay, timeDate, regWrData;
  logic [3:0] sqSrc, regAddr;
  logic [1:0] alarmFlags;
  logic irqPinN, irqPinOe;
  int checks = 0, failures = 0;
  bit done = 0;

  alarm_irq_unit u_alarm_irq_unit (
    .clk(clk), .rstN(rstN), .secTick(secTick), .timeSec(timeSec),
    .timeMin(timeMin), .timeHour(timeHour), .timeDay(timeDay),
    .timeDate(timeDate), .sqSrc(sqSrc), .onBattery(onBattery),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .alarmFlags(alarmFlags), .irqPinN(irqPinN), .irqPinOe(irqPinOe)
  );

  // a1 sec,min,hr,dd | a2 min,hr,dd | time sec,min,hr,day,date | expected {f2,f1}
  localparam int NV = 8;
  localparam logic [97:0] VECS [NV] = '{
    {8'h80,8'h80,8'h80,8'h80, 8'h80,8'h80,8'h80, 8'h45,8'h30,8'h12,8'h03,8'h15, 2'b01}, // R2 all masked
    {8'h45,8'h80,8'h80,8'h80, 8'h80,8'h80,8'h80, 8'h00,8'h30,8'h12,8'h03,8'h15, 2'b10}, // R2 R4
    {8'h45,8'h30,8'h80,8'h80, 8'h30,8'h80,8'h80, 8'h45,8'h30,8'h12,8'h03,8'h15, 2'b01}, // R2 R4 sec not 00
    {8'h45,8'h30,8'h12,8'h80, 8'h30,8'h12,8'h80, 8'h00,8'h30,8'h12,8'h03,8'h15, 2'b10}, // R4
    {8'h00,8'h30,8'h12,8'h15, 8'h30,8'h12,8'h43, 8'h00,8'h30,8'h12,8'h03,8'h15, 2'b11}, // R3 date / day
    {8'h00,8'h30,8'h12,8'h44, 8'h30,8'h12,8'h15, 8'h00,8'h30,8'h12,8'h03,8'h15, 2'b10}, // R3 day mismatch
    {8'h00,8'h30,8'h52,8'h80, 8'h30,8'h72,8'h80, 8'h00,8'h30,8'h72,8'h03,8'h15, 2'b10}, // R10 PM bit
    {8'h00,8'h31,8'h80,8'h80, 8'h31,8'h80,8'h80, 8'h00,8'h30,8'h12,8'h03,8'h15, 2'b00}  // R2 minute miss
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  initial begin
    #900000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [97:0] vec;
    rstN = 0; secTick = 0; onBattery = 0; regWrEn = 0; regAddr = 0; regWrData = 0;
    timeSec = 0; timeMin = 0; timeHour = 0; timeDay = 0; timeDate = 0; sqSrc = 4'b0000;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 flags", {6'd0, alarmFlags}, 8'h00);
    check("R1 pin", {7'd0, irqPinN}, 8'h01);
    check("R1 oe", {7'd0, irqPinOe}, 8'h01);

    // R1 default rate 11, R8 square-wave selection
    wr(7, 8'h18);
    sqSrc = 4'b1000; @(negedge clk);
    check("R1 R8 rate11 high", {7'd0, irqPinN}, 8'h01);
    sqSrc = 4'b0111; @(negedge clk);
    check("R1 R8 rate11 low", {7'd0, irqPinN}, 8'h00);
    wr(7, 8'h00);
    sqSrc = 4'b0001; @(negedge clk);
    check("R8 rate00 high", {7'd0, irqPinN}, 8'h01);
    sqSrc = 4'b1110; @(negedge clk);
    check("R8 rate00 low", {7'd0, irqPinN}, 8'h00);
    wr(7, 8'h08);
    sqSrc = 4'b0010; @(negedge clk);
    check("R8 rate01", {7'd0, irqPinN}, 8'h01);
    wr(7, 8'h1C);

    // Vector walk: R2 R3 R4 R10
    for (int v = 0; v < NV; v++) begin
      vec = VECS[v];
      for (int i = 0; i < 7; i++) wr(4'(i), vec[97-8*i -: 8]);
      timeSec = vec[97-8*7 -: 8]; timeMin = vec[97-8*8 -: 8];
      timeHour = vec[97-8*9 -: 8]; timeDay = vec[97-8*10 -: 8];
      timeDate = vec[97-8*11 -: 8];
      wr(8, 8'h00);
      tick();
      check($sformatf("R2 R3 R4 R10 vector %0d", v), {6'd0, alarmFlags}, {6'd0, vec[1:0]});
    end

    // All masked, seconds 00: both match
    for (int i = 0; i < 7; i++) wr(4'(i), 8'h80);
    timeSec = 8'h00;
    wr(8, 8'h00);
    repeat (4) @(negedge clk);
    check("R5 no tick no set", {6'd0, alarmFlags}, 8'h00);
    tick();
    check("R5 set on tick", {6'd0, alarmFlags}, 8'h03);
    wr(8, 8'h03);
    check("R6 write ones keeps", {6'd0, alarmFlags}, 8'h03);
    wr(8, 8'h02);
    check("R6 clear f1 only", {6'd0, alarmFlags}, 8'h02);

    // R7 interrupt pin
    wr(7, 8'h05);
    check("R7 ie1 with f1=0", {7'd0, irqPinN}, 8'h01);
    wr(7, 8'h06);
    check("R7 ie2 with f2=1", {7'd0, irqPinN}, 8'h00);
    wr(7, 8'h04);
    check("R7 no enables", {7'd0, irqPinN}, 8'h01);

    // R5 in square mode flags still set
    wr(7, 8'h00);
    wr(8, 8'h00);
    tick();
    check("R5 square mode sets", {6'd0, alarmFlags}, 8'h03);

    // R6 set beats clear on same edge
    @(negedge clk);
    secTick = 1'b1; regWrEn = 1'b1; regAddr = 4'd8; regWrData = 8'h00;
    @(negedge clk);
    secTick = 1'b0; regWrEn = 1'b0;
    check("R6 set wins", {6'd0, alarmFlags}, 8'h03);

    // R9 battery drive
    onBattery = 1'b1; @(negedge clk);
    check("R9 released", {7'd0, irqPinOe}, 8'h00);
    wr(7, 8'h40);
    check("R9 battery drive", {7'd0, irqPinOe}, 8'h01);
    onBattery = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule